// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block counts ticks of a divided bus clock in a 16-bit up-counter and raises an interrupt request each time the count reaches a programmed limit. A 3-bit rate field picks one of seven tick rates, from the bus clock itself down to one tick every 64 bus cycles. On the tick where the counter equals the limit, the counter wraps to zero and a sticky overflow flag is set. The flag drives the interrupt line only while the enable bit is set. Software clears the flag with a fixed sequence: it reads the control byte while the flag is up, then writes the control byte with the flag bit at 0.

A CPU reaches the block through a byte-wide, single-cycle register port. The port has a select strobe, a write strobe, an offset and a write byte. Read data comes back combinationally in the same cycle. Five byte registers sit at consecutive offsets: control, counter high, counter low, limit high and limit low. The limit is a 16-bit value written as two bytes. The high byte waits in a holding buffer and takes effect together with the low byte. After reset the timer is halted, the counter is zero and the limit is all ones.

Top module: `pit_timer`

## Requirements
- R1: After reset, the control byte reads 0x20 (halted, all other bits 0), both counter bytes read 0x00, both limit bytes read 0xFF, and irq is 0.
- R2: Offset 0 is control, laid out as: bit 7 overflow flag, bit 6 interrupt enable, bit 5 halt, bits 2:0 rate. Bits 4 and 3 always read 0. Offsets 1 and 2 return the counter high and low bytes, offsets 3 and 4 return the limit high and low bytes, and any other offset reads 0x00.
- R3: With rate code n from 0 to 6, the counter advances once every 2^n bus cycles, driven by a free-running 6-bit prescaler that only runs while the timer is not halted. Code 7 behaves like code 6.
- R4: While the halt bit is 1, neither the counter nor the prescaler changes.
- R5: On a tick where the counter equals the limit, the counter becomes 0x0000 and the overflow flag becomes 1 on that same clock edge.
- R6: A control write with bit 4 set clears the counter and the prescaler on that edge. This clear takes priority over any tick.
- R7: The overflow flag clears only on a control write with bit 7 at 0 that follows a control read made while the flag was 1, with no other control write in between. Writing 1 to bit 7, or skipping the read, leaves the flag unchanged. A new overflow on the same edge keeps the flag set.
- R8: irq is 1 exactly when both the overflow flag and the interrupt enable are 1.
- R9: A write to the limit high byte (offset 3) changes nothing that can be read until the limit low byte (offset 4) is written. At that point both bytes take effect together.
- R10: Writes to the counter bytes (offsets 1 and 2) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of the access |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches, on every cycle:
- that no tick occurs while the timer is halted and the counter holds still;
- that a tick arrives every cycle at rate 0;
- that a counter-clear write and a wrap at the limit both leave a zero count;
- that the flag can only fall after the read-then-write sequence;
- that the limit changes only on a low-byte write.

The other behaviours can only be shown by the bench scenarios, which compare every read and the irq line against a reference model:
- the exact tick spacing for each rate code;
- the byte layout of each register;
- the reset values;
- that a limit high byte written alone has no effect;
- that counter writes are ignored.

// File: rtl/pit_pkg.sv
// Package: shared offsets, control-bit positions and configuration type for
// the periodic interval timer. Assumes an 8-bit register port.
package pit_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_CNT_HI = 3'd1,
        REG_CNT_LO = 3'd2,
        REG_LIM_HI = 3'd3,
        REG_LIM_LO = 3'd4
    } pit_reg_e;

    localparam int BIT_FLAG  = 7;
    localparam int BIT_IE    = 6;
    localparam int BIT_HALT  = 5;
    localparam int BIT_CLEAR = 4;

    typedef struct packed {
        logic       ie;
        logic       halt;
        logic [2:0] rate;
    } pit_cfg_t;
endpackage

// File: rtl/pit_prescaler.sv
// Prescaler: a free-running counter that emits one-cycle ticks at bus/2^rate.
// Assumes rate codes above DIV_STAGES are clamped to DIV_STAGES, and that
// 2^RATE_W > DIV_STAGES.
module pit_prescaler #(
    parameter int RATE_W     = 3,
    parameter int DIV_STAGES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam logic [RATE_W-1:0] MAX_RATE = RATE_W'(DIV_STAGES);

    logic [DIV_STAGES-1:0] pre_q;
    logic [DIV_STAGES:0]   tap;
    logic [RATE_W-1:0]     eff_rate;

    // Tap k is high when the low k prescaler bits are all ones.
    assign tap[0] = 1'b1;
    for (genvar k = 1; k <= DIV_STAGES; k++) begin : g_tap
        assign tap[k] = &pre_q[k-1:0];
    end

    // Clamp rate codes beyond the last stage.
    always_comb begin
        eff_rate = (rate > MAX_RATE) ? MAX_RATE : rate;
    end

    assign tick = run & tap[eff_rate];

    // Advance the prescaler while running; the clear request wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clear)
            pre_q <= '0;
        else if (run)
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/pit_counter.sv
// Counter and limit: counts ticks up to the limit, then wraps to zero and
// pulses wrap. The limit is loaded as a high byte held in a buffer and a low
// byte that commits both halves. Assumes CNT_W is twice the byte width.
module pit_counter #(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    clear,
    input  logic                    lim_hi_wr,
    input  logic                    lim_lo_wr,
    input  logic [pit_pkg::BYTE_W-1:0] wbyte,
    output logic [CNT_W-1:0]        count,
    output logic [CNT_W-1:0]        limit,
    output logic                    wrap
);
    localparam int HALF = CNT_W / 2;

    logic [HALF-1:0] hi_buf_q;

    assign wrap = tick & ~clear & (count == limit);

    // Count ticks; clear wins over a tick, and a match wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (tick)
            count <= (count == limit) ? '0 : count + 1'b1;
    end

    // Hold the high byte of the limit until the low byte is written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_buf_q <= '1;
        else if (lim_hi_wr)
            hi_buf_q <= wbyte[HALF-1:0];
    end

    // Commit both halves of the limit on a low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit <= '1;
        else if (lim_lo_wr)
            limit <= {hi_buf_q, wbyte[HALF-1:0]};
    end
endmodule

// File: rtl/pit_ctrl.sv
// Control state: enable, halt and rate fields, the sticky overflow flag, and
// the arm bit that records a control read made while the flag was set.
// Assumes at most one control access per cycle.
module pit_ctrl (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_rd,
    input  logic              wr_flag_bit,
    input  pit_pkg::pit_cfg_t cfg_in,
    input  logic              wrap,
    output pit_pkg::pit_cfg_t cfg,
    output logic              flag,
    output logic              arm
);
    logic clr_ok;

    assign clr_ok = ctrl_wr & arm & ~wr_flag_bit;

    // Load the configuration fields on a control write; reset leaves the timer halted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.ie   <= 1'b0;
            cfg.halt <= 1'b1;
            cfg.rate <= '0;
        end else if (ctrl_wr) begin
            cfg <= cfg_in;
        end
    end

    // Sticky flag: set by a wrap, cleared only by the armed write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (wrap)
            flag <= 1'b1;
        else if (clr_ok)
            flag <= 1'b0;
    end

    // Arm on a control read while the flag is set; any control write disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm <= 1'b0;
        else if (ctrl_wr)
            arm <= 1'b0;
        else if (ctrl_rd && flag)
            arm <= 1'b1;
    end
endmodule

// File: rtl/pit_timer.sv
// Top: periodic interval timer with a byte register port. Decodes accesses,
// wires the prescaler, the counter and the control state, and muxes read data
// combinationally. Assumes single-cycle accesses qualified by bus_sel.
module pit_timer #(
    parameter int CNT_W      = 16,
    parameter int RATE_W     = 3,
    parameter int DIV_STAGES = 6,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    import pit_pkg::*;

    localparam int HALF = CNT_W / 2;

    logic              ctrl_wr, ctrl_rd, clr_cnt, lim_hi_wr, lim_lo_wr;
    logic              tick, wrap, flag, arm;
    logic              cfg_ie, cfg_halt;
    logic [RATE_W-1:0] cfg_rate;
    logic [CNT_W-1:0]  count, limit;
    pit_cfg_t          cfg, cfg_in;

    // Decode one access per cycle into register strobes.
    always_comb begin
        ctrl_wr   = bus_sel &  bus_wr & (bus_addr == ADDR_W'(REG_CTRL));
        ctrl_rd   = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(REG_CTRL));
        lim_hi_wr = bus_sel &  bus_wr & (bus_addr == ADDR_W'(REG_LIM_HI));
        lim_lo_wr = bus_sel &  bus_wr & (bus_addr == ADDR_W'(REG_LIM_LO));
        clr_cnt   = ctrl_wr & bus_wdata[BIT_CLEAR];
    end

    // Collect the configuration fields from the write byte.
    always_comb begin
        cfg_in.ie   = bus_wdata[BIT_IE];
        cfg_in.halt = bus_wdata[BIT_HALT];
        cfg_in.rate = bus_wdata[2:0];
    end

    assign cfg_ie   = cfg.ie;
    assign cfg_halt = cfg.halt;
    assign cfg_rate = cfg.rate;

    pit_prescaler #(
        .RATE_W    (RATE_W),
        .DIV_STAGES(DIV_STAGES)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (~cfg_halt),
        .clear(clr_cnt),
        .rate (cfg_rate),
        .tick (tick)
    );

    pit_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (clr_cnt),
        .lim_hi_wr(lim_hi_wr),
        .lim_lo_wr(lim_lo_wr),
        .wbyte    (bus_wdata),
        .count    (count),
        .limit    (limit),
        .wrap     (wrap)
    );

    pit_ctrl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_rd    (ctrl_rd),
        .wr_flag_bit(bus_wdata[BIT_FLAG]),
        .cfg_in     (cfg_in),
        .wrap       (wrap),
        .cfg        (cfg),
        .flag       (flag),
        .arm        (arm)
    );

    // Return the addressed register byte in the access cycle.
    always_comb begin
        case (bus_addr)
            ADDR_W'(REG_CTRL):   bus_rdata = {flag, cfg_ie, cfg_halt, 2'b00, cfg_rate};
            ADDR_W'(REG_CNT_HI): bus_rdata = count[HALF +: 8];
            ADDR_W'(REG_CNT_LO): bus_rdata = count[0 +: 8];
            ADDR_W'(REG_LIM_HI): bus_rdata = limit[HALF +: 8];
            ADDR_W'(REG_LIM_LO): bus_rdata = limit[0 +: 8];
            default:             bus_rdata = 8'h00;
        endcase
    end

    assign irq = flag & cfg_ie;
endmodule

// File: rtl/pit_timer_chk.sv
// Checker: cycle-by-cycle properties of the timer, bound to pit_timer.
// Assumes it sees the top-level internal nets named in the bind below.
module pit_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int RATE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              cfg_halt,
    input logic [RATE_W-1:0] cfg_rate,
    input logic              clr_cnt,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  limit,
    input logic              flag,
    input logic              arm,
    input logic              ctrl_wr,
    input logic              wr_bit7,
    input logic              lim_lo_wr
);
    AST_NO_TICK_HALTED: assert property (@(posedge clk) disable iff (!rst_n) cfg_halt |-> !tick); // R4
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (cfg_halt && !clr_cnt) |=> $stable(count)); // R4
    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_halt && cfg_rate == '0) |-> tick); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (tick && !clr_cnt && count == limit) |=> (count == '0 && flag)); // R5
    AST_CLEAR_COUNT: assert property (@(posedge clk) disable iff (!rst_n) clr_cnt |=> count == '0); // R6
    AST_FLAG_SEQ: assert property (@(posedge clk) disable iff (!rst_n) $fell(flag) |-> $past(arm && ctrl_wr && !wr_bit7)); // R7
    AST_LIMIT_PAIR: assert property (@(posedge clk) disable iff (!rst_n) !lim_lo_wr |=> $stable(limit)); // R9
endmodule

bind pit_timer pit_timer_chk #(
    .CNT_W (CNT_W),
    .RATE_W(RATE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cfg_halt (cfg_halt),
    .cfg_rate (cfg_rate),
    .clr_cnt  (clr_cnt),
    .count    (count),
    .limit    (limit),
    .flag     (flag),
    .arm      (arm),
    .ctrl_wr  (ctrl_wr),
    .wr_bit7  (bus_wdata[7]),
    .lim_lo_wr(lim_lo_wr)
);

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Reference model state
    int m_pre, m_cnt, m_lim, m_buf, m_rate;
    bit m_flag, m_arm, m_ie, m_halt;

    pit_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void m_reset();
        m_pre = 0; m_cnt = 0; m_lim = 16'hFFFF; m_buf = 8'hFF;
        m_rate = 0; m_flag = 0; m_arm = 0; m_ie = 0; m_halt = 1;
    endfunction

    function automatic bit m_tick();
        int r = (m_rate > 6) ? 6 : m_rate;
        int mask = (1 << r) - 1;
        return !m_halt && ((m_pre & mask) == mask);
    endfunction

    function automatic logic [7:0] m_read(int a);
        case (a)
            0: return {m_flag, m_ie, m_halt, 2'b00, 3'(m_rate)};
            1: return 8'(m_cnt >> 8);
            2: return 8'(m_cnt);
            3: return 8'(m_lim >> 8);
            4: return 8'(m_lim);
            default: return 8'h00;
        endcase
    endfunction

    function automatic void m_update(bit s, bit w, int a, logic [7:0] d);
        bit t = m_tick();
        bit cwr = s && w && a == 0;
        bit crd = s && !w && a == 0;
        bit clr = cwr && d[4];
        bit wrp = t && !clr && (m_cnt == m_lim);
        bit fclr = cwr && m_arm && !d[7];
        int n_cnt = clr ? 0 : (t ? ((m_cnt == m_lim) ? 0 : m_cnt + 1) : m_cnt);
        int n_pre = clr ? 0 : (!m_halt ? ((m_pre + 1) % 64) : m_pre);
        bit n_flag = wrp ? 1'b1 : (fclr ? 1'b0 : m_flag);
        bit n_arm = cwr ? 1'b0 : ((crd && m_flag) ? 1'b1 : m_arm);
        if (cwr) begin m_ie = d[6]; m_halt = d[5]; m_rate = int'(d[2:0]); end
        if (s && w && a == 4) m_lim = (m_buf << 8) | int'(d);
        if (s && w && a == 3) m_buf = int'(d);
        m_cnt = n_cnt; m_pre = n_pre; m_flag = n_flag; m_arm = n_arm;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // One bus cycle, entered at a falling edge: drive, check, clock, model.
    task automatic step(bit s, bit w, int a, logic [7:0] d, string tag);
        bus_sel = s; bus_wr = w; bus_addr = 3'(a); bus_wdata = d;
        #1;
        if (s && !w) check(tag, bus_rdata, m_read(a), "rdata");
        check(tag, {7'b0, irq}, {7'b0, m_flag & m_ie}, "irq");
        @(posedge clk);
        m_update(s, w, a, d);
        @(negedge clk);
    endtask

    task automatic rd(int a, string tag); step(1, 0, a, 8'h00, tag); endtask
    task automatic wr(int a, logic [7:0] d, string tag); step(1, 1, a, d, tag); endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) rd(a, "R1");
        // R2 layout and unused offset
        rd(5, "R2");
        wr(0, 8'hFF, "R2");
        rd(0, "R2");
        // R3 rates 0, 3, 7
        wr(0, 8'h10, "R3");
        for (int i = 0; i < 20; i++) rd(2, "R3");
        wr(0, 8'h13, "R3");
        for (int i = 0; i < 40; i++) rd(2, "R3");
        wr(0, 8'h17, "R3");
        for (int i = 0; i < 140; i++) rd(2, "R3");
        // R4 halt
        wr(0, 8'h20, "R4");
        for (int i = 0; i < 10; i++) rd(2, "R4");
        // R5 wrap at a small limit
        wr(3, 8'h00, "R5");
        wr(4, 8'h03, "R5");
        wr(0, 8'h10, "R5");
        for (int i = 0; i < 12; i++) rd((i % 2 == 0) ? 2 : 0, "R5");
        // R6 clear bit mid-count
        wr(0, 8'h10, "R6");
        rd(2, "R6");
        wr(0, 8'h10, "R6");
        rd(2, "R6");
        // R7 flag clear sequence
        wr(0, 8'h30, "R7");
        wr(0, 8'h10, "R7");
        for (int i = 0; i < 6; i++) rd(2, "R7");
        wr(0, 8'h20, "R7");
        rd(0, "R7");
        wr(0, 8'hA0, "R7");
        rd(0, "R7");
        wr(0, 8'h20, "R7");
        rd(0, "R7");
        // R8 interrupt gating
        wr(0, 8'h50, "R8");
        for (int i = 0; i < 6; i++) rd(2, "R8");
        wr(0, 8'h10, "R8");
        rd(2, "R8");
        // R9 buffered limit high byte
        wr(0, 8'h30, "R9");
        wr(3, 8'h12, "R9");
        rd(3, "R9");
        rd(4, "R9");
        wr(4, 8'h34, "R9");
        rd(3, "R9");
        rd(4, "R9");
        // R10 counter writes ignored
        wr(0, 8'h10, "R10");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 8'h00, "R10");
        wr(1, 8'hFF, "R10");
        wr(2, 8'hFF, "R10");
        rd(2, "R10");
        rd(1, "R10");

        // Constrained random mix
        wr(3, 8'h00, "R9");
        wr(4, 8'h10, "R9");
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom % 100);
            if (r < 45) begin
                int a = int'($urandom % 6);
                rd(a, (a == 0) ? "R7" : (a < 3) ? "R5" : (a < 5) ? "R9" : "R2");
            end else if (r < 55) begin
                logic [7:0] d = 8'($urandom);
                d[5] = ($urandom % 8 == 0);
                d[4] = ($urandom % 16 == 0);
                d[2:0] = 3'($urandom % 4);
                wr(0, d, "R8");
            end else if (r < 62) begin
                wr(3, ($urandom % 4 == 0) ? 8'h01 : 8'h00, "R9");
            end else if (r < 70) begin
                wr(4, 8'($urandom % 48), "R9");
            end else if (r < 75) begin
                wr(1 + int'($urandom % 2), 8'($urandom), "R10");
            end else begin
                step(0, 0, 0, 8'h00, "R3");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule